// File: doc/BRIEF.md
# Sticky Event Interrupt Controller

This block collects single-cycle event pulses from a radio transceiver core into an eight-bit pending register. A programmable enable register gates the events before they are latched. A pending bit stays set after its event pulse ends. All pending bits are OR-combined into one registered, active-high interrupt line for the host controller.

The host uses a small register port. One address holds the enable register, which can be read and written. A second address holds the pending register, which is read-only. Reading the pending register returns its contents and clears every bit in the same access, and the interrupt line then drops one cycle later. The phase-locked-loop lock and unlock events cancel each other: either event removes a pending bit of the opposite kind. Pending bit 4 is shared by two sources, wake-up completion and measurement completion.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After synchronous reset the pending register reads 0x00 and `irq_out` is low.
- R2: The enable register is written at address 0x0E when `reg_wr` is high. Reading 0x0E returns the stored value unchanged, and reset sets it to 0x00. Any address other than 0x0E or 0x0F reads as 0x00.
- R3: An event whose enable bit is 0 is not latched, so its pending bit stays 0 and `irq_out` stays low.
- R4: An enabled event sets its pending bit at the clock edge on which its pulse is sampled. The bit positions are: 7 supply low, 6 buffer access violation, 5 address match, 4 shared, 3 frame end, 2 receive start, 1 PLL unlock, 0 PLL lock. The bit then stays set after the pulse ends. Several events in one cycle set several bits.
- R5: A read at address 0x0F (`reg_rd` high) returns the pending bits on `reg_rdata` in that cycle and clears all of them at the same clock edge.
- R6: `irq_out` is registered. It goes high one clock after any pending bit becomes set, and goes low one clock after the pending register becomes all zero.
- R7: Pending bit 4 is set by either `ev_wake_done` or `ev_meas_done`, or by both.
- R8: A PLL lock pulse clears a pending unlock bit (bit 1), and a PLL unlock pulse clears a pending lock bit (bit 0). This happens whether or not the clearing event is itself enabled.
- R9: If an enabled event arrives in the same cycle as a pending-register read, the read returns the old value and the new event's bit remains set after the clear.
- R10: Writes to address 0x0F change neither the pending register nor the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_pll_lock | input | 1 | PLL lock event pulse |
| ev_pll_unlock | input | 1 | PLL unlock event pulse |
| ev_rx_begin | input | 1 | Receive start event pulse |
| ev_frame_end | input | 1 | Frame receive/transmit end pulse |
| ev_wake_done | input | 1 | Wake-up reached idle-off state pulse |
| ev_meas_done | input | 1 | Channel/energy measurement finished pulse |
| ev_addr_match | input | 1 | Address match event pulse |
| ev_buf_viol | input | 1 | Frame buffer access violation pulse |
| ev_supply_low | input | 1 | Supply below threshold pulse |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid in the same cycle as the address |
| irq_out | output | 1 | Combined active-high interrupt |

## Verification
A pending bit that is lost, a bit that sets without being enabled, or a bit that lands in the wrong position shows on `reg_rdata` at the very next pending-register read. It also shows on `irq_out` one clock after the bad latch. A clear that misses the same-cycle race, or a lock/unlock cancel that does not happen, leaves a wrong bit visible in the following read. A corrupted enable register shows directly on a read of 0x0E and, one cycle after the next event, as a missing or extra interrupt.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NSRC   = 8;
    localparam int DATA_W = 8;

    // pending bit positions
    localparam int B_PLL_LOCK   = 0;
    localparam int B_PLL_UNLOCK = 1;
    localparam int B_RX_BEGIN   = 2;
    localparam int B_FRAME_END  = 3;
    localparam int B_SHARED     = 4;
    localparam int B_ADDR_MATCH = 5;
    localparam int B_BUF_VIOL   = 6;
    localparam int B_SUPPLY_LOW = 7;

    typedef struct packed {
        logic supply_low;
        logic buf_viol;
        logic addr_match;
        logic meas_done;
        logic wake_done;
        logic frame_end;
        logic rx_begin;
        logic pll_unlock;
        logic pll_lock;
    } evt_raw_t;

    typedef struct packed {
        logic wr_mask;
        logic rd_clear;
    } acc_t;

    function automatic logic [NSRC-1:0] fold_events(evt_raw_t e);
        logic [NSRC-1:0] v;
        v               = '0;
        v[B_PLL_LOCK]   = e.pll_lock;
        v[B_PLL_UNLOCK] = e.pll_unlock;
        v[B_RX_BEGIN]   = e.rx_begin;
        v[B_FRAME_END]  = e.frame_end;
        v[B_SHARED]     = e.wake_done | e.meas_done;
        v[B_ADDR_MATCH] = e.addr_match;
        v[B_BUF_VIOL]   = e.buf_viol;
        v[B_SUPPLY_LOW] = e.supply_low;
        return v;
    endfunction

    // opposite-partner cancel vector: each PLL event wipes the other bit
    function automatic logic [NSRC-1:0] cancel_events(evt_raw_t e);
        logic [NSRC-1:0] c;
        c               = '0;
        c[B_PLL_LOCK]   = e.pll_unlock;
        c[B_PLL_UNLOCK] = e.pll_lock;
        return c;
    endfunction

endpackage

// File: rtl/irqc_event_map.sv
module irqc_event_map
    import irqc_pkg::*;
(
    input  evt_raw_t        raw,
    output logic [NSRC-1:0] set_vec,
    output logic [NSRC-1:0] cancel_vec
);
    always_comb begin
        set_vec    = fold_events(raw);
        cancel_vec = cancel_events(raw);
    end
endmodule

// File: rtl/irqc_reg_port.sv
module irqc_reg_port
    import irqc_pkg::*;
#(
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  MASK_ADDR = 8'h0E,
    parameter logic [AW-1:0]  STAT_ADDR = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   pend_q,
    output logic [NSRC-1:0]   mask_q,
    output acc_t              acc,
    output logic [DATA_W-1:0] rdata
);
    logic hit_mask, hit_stat;

    always_comb begin
        hit_mask     = (addr == MASK_ADDR);
        hit_stat     = (addr == STAT_ADDR);
        acc.wr_mask  = wr & hit_mask;
        acc.rd_clear = rd & hit_stat;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (acc.wr_mask)
            mask_q <= wdata[NSRC-1:0];
    end

    always_comb begin
        rdata = '0;
        if (hit_mask)
            rdata[NSRC-1:0] = mask_q;
        else if (hit_stat)
            rdata[NSRC-1:0] = pend_q;
    end

    // R2
    mask_reset_chk: assert property (@(posedge clk) rst |=> (mask_q == '0));

    // R10
    stat_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_stat) |=> $stable(mask_q));

    // R2
    mask_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && hit_mask) |=> (mask_q == $past(wdata[NSRC-1:0])));
endmodule

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank
    import irqc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] cancel_vec,
    input  logic [NSRC-1:0] mask_q,
    input  logic            rd_clear,
    output logic [NSRC-1:0] pend_q
);
    logic [NSRC-1:0] take;

    assign take = set_vec & mask_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else
                pend_q[i] <= take[i] | (pend_q[i] & ~cancel_vec[i] & ~rd_clear);
        end

        // R3
        masked_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (set_vec[i] && !mask_q[i] && !pend_q[i]) |=> !pend_q[i]);

        // R4
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (pend_q[i] && !rd_clear && !cancel_vec[i]) |=> pend_q[i]);

        // R9
        race_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (rd_clear && set_vec[i] && mask_q[i]) |=> pend_q[i]);

        // R8
        cancel_chk: assert property (@(posedge clk) disable iff (rst)
            (cancel_vec[i] && !(set_vec[i] && mask_q[i])) |=> !pend_q[i]);
    end

    // R5
    clear_all_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && (take == '0)) |=> (pend_q == '0));
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int             AW        = 8,
    parameter logic [AW-1:0]  MASK_ADDR = 8'h0E,
    parameter logic [AW-1:0]  STAT_ADDR = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_pll_lock,
    input  logic              ev_pll_unlock,
    input  logic              ev_rx_begin,
    input  logic              ev_frame_end,
    input  logic              ev_wake_done,
    input  logic              ev_meas_done,
    input  logic              ev_addr_match,
    input  logic              ev_buf_viol,
    input  logic              ev_supply_low,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    evt_raw_t        raw;
    logic [NSRC-1:0] set_vec, cancel_vec, mask_q, pend_q;
    acc_t            acc;
    logic            irq_q;

    always_comb begin
        raw.pll_lock   = ev_pll_lock;
        raw.pll_unlock = ev_pll_unlock;
        raw.rx_begin   = ev_rx_begin;
        raw.frame_end  = ev_frame_end;
        raw.wake_done  = ev_wake_done;
        raw.meas_done  = ev_meas_done;
        raw.addr_match = ev_addr_match;
        raw.buf_viol   = ev_buf_viol;
        raw.supply_low = ev_supply_low;
    end

    irqc_event_map u_map (
        .raw        (raw),
        .set_vec    (set_vec),
        .cancel_vec (cancel_vec)
    );

    irqc_reg_port #(
        .AW        (AW),
        .MASK_ADDR (MASK_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_port (
        .clk    (clk),
        .rst    (rst),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .wdata  (reg_wdata),
        .pend_q (pend_q),
        .mask_q (mask_q),
        .acc    (acc),
        .rdata  (reg_rdata)
    );

    irqc_pend_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .set_vec    (set_vec),
        .cancel_vec (cancel_vec),
        .mask_q     (mask_q),
        .rd_clear   (acc.rd_clear),
        .pend_q     (pend_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= 1'b0;
        else
            irq_q <= |pend_q;
    end

    assign irq_out = irq_q;

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|pend_q) |=> irq_out);

    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q == '0) |=> !irq_out);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq_out && pend_q == '0));
endmodule

// File: tb/test_evt_irq_ctrl.sv
module test_evt_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [8:0] evb = '0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    // evb index: 0 lock,1 unlock,2 rx_begin,3 frame_end,4 wake_done,
    //            5 addr_match,6 buf_viol,7 supply_low,8 meas_done
    evt_irq_ctrl i_evt_irq_ctrl (
        .clk(clk), .rst(rst),
        .ev_pll_lock(evb[0]), .ev_pll_unlock(evb[1]),
        .ev_rx_begin(evb[2]), .ev_frame_end(evb[3]),
        .ev_wake_done(evb[4]), .ev_meas_done(evb[8]),
        .ev_addr_match(evb[5]), .ev_buf_viol(evb[6]),
        .ev_supply_low(evb[7]),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(logic [7:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(logic [7:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic pulse(logic [8:0] e);
        evb = e;
        tick();
        evb = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 irq after reset", {7'b0, irq_out}, 8'h00);
        read_reg(8'h0E, v); check("R2 mask reset", v, 8'h00);
        read_reg(8'h0F, v); check("R1 pending reset", v, 8'h00);
    endtask

    task automatic t_mask_rw();
        logic [7:0] v;
        write_reg(8'h0E, 8'hA5);
        read_reg(8'h0E, v); check("R2 mask readback", v, 8'hA5);
        read_reg(8'h0E, v); check("R2 mask read unchanged", v, 8'hA5);
        read_reg(8'h10, v); check("R2 unmapped address", v, 8'h00);
    endtask

    task automatic t_masked();
        logic [7:0] v;
        write_reg(8'h0E, 8'hFE);
        pulse(9'h001);
        tick();
        check("R3 irq stays low", {7'b0, irq_out}, 8'h00);
        read_reg(8'h0F, v); check("R3 masked not latched", v, 8'h00);
    endtask

    task automatic t_each_source();
        logic [7:0] v;
        write_reg(8'h0E, 8'hFF);
        for (int k = 0; k < 9; k++) begin
            logic [7:0] exp;
            exp = (k == 8) ? 8'h10 : (8'h01 << k);
            pulse(9'h001 << k);
            check("R6 irq not yet", {7'b0, irq_out}, 8'h00);
            tick();
            check("R6 irq one clock later", {7'b0, irq_out}, 8'h01);
            read_reg(8'h0F, v); check("R4 bit position and sticky", v, exp);
            check("R6 irq held over clear edge", {7'b0, irq_out}, 8'h01);
            tick();
            check("R6 irq drops", {7'b0, irq_out}, 8'h00);
            read_reg(8'h0F, v); check("R5 cleared by read", v, 8'h00);
        end
    endtask

    task automatic t_multi_and_shared();
        logic [7:0] v;
        pulse(9'h0E0);
        read_reg(8'h0F, v); check("R4 several bits", v, 8'hE0);
        pulse(9'h110);
        read_reg(8'h0F, v); check("R7 shared both sources", v, 8'h10);
    endtask

    task automatic t_pll();
        logic [7:0] v;
        pulse(9'h002);
        pulse(9'h001);
        read_reg(8'h0F, v); check("R8 lock clears unlock", v, 8'h01);
        pulse(9'h001);
        pulse(9'h002);
        read_reg(8'h0F, v); check("R8 unlock clears lock", v, 8'h02);
        write_reg(8'h0E, 8'h02);
        pulse(9'h002);
        pulse(9'h001);
        read_reg(8'h0F, v); check("R8 masked lock still cancels", v, 8'h00);
        write_reg(8'h0E, 8'hFF);
    endtask

    task automatic t_race();
        logic [7:0] v;
        pulse(9'h004);
        reg_addr = 8'h0F; reg_rd = 1'b1; evb = 9'h008;
        #1 v = reg_rdata;
        tick();
        reg_rd = 1'b0; evb = '0;
        check("R9 read returns old value", v, 8'h04);
        read_reg(8'h0F, v); check("R9 new bit survives clear", v, 8'h08);
    endtask

    task automatic t_wr_ignore();
        logic [7:0] v;
        pulse(9'h020);
        write_reg(8'h0F, 8'h00);
        read_reg(8'h0E, v); check("R10 mask untouched", v, 8'hFF);
        read_reg(8'h0F, v); check("R10 pending untouched", v, 8'h20);
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        t_reset();
        t_mask_rw();
        t_masked();
        t_each_source();
        t_multi_and_shared();
        t_pll();
        t_race();
        t_wr_ignore();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule